// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block gives a set of requesters a way to build atomic read-modify-write sequences, such as a spin lock where a word reading 0 is free and 1 is held. A requester first issues a linked load. The monitor then records a reservation for that requester on the aligned word that holds the address. The requester later issues a conditional store to the same word. The monitor lets that store reach memory only if nothing has written the word in between. It reports 1 on success and 0 on failure, so the pipeline can write that value back to the destination register. On failure the software loop retries.

Each requester has one reservation slot: a valid bit and a reserved address. All requesters present one operation per cycle on parallel lanes. Within a cycle the monitor orders the lanes by index, lowest first. It drives two outputs: a combinational write-permission vector for the memory, and a success vector for the conditional stores. The memory array, the coherence protocol and the pipeline are outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: A linked load (lane code 2'b01) sets that requester's reservation. A conditional store (code 2'b10) from the same requester to the same word, with no committed write to that word in between, drives `sc_ok` and `commit` high for that lane in the same cycle.
- R2: A conditional store from a requester that holds no reservation fails: `sc_ok` and `commit` stay low.
- R3: A conditional store to a word other than the reserved word fails.
- R4: A conditional store clears its requester's reservation whether it succeeds or fails, so a second conditional store with no new linked load fails.
- R5: A committed write by another requester to the reserved word clears the reservation at the next clock edge. A committed write to a different word leaves the reservation in place.
- R6: A plain store (code 2'b11) by the reserving requester to its own reserved word also clears the reservation.
- R7: Lanes within one cycle are ordered by index, lowest first. When several conditional stores with valid reservations target one word in the same cycle, only the lowest-indexed one succeeds.
- R8: A linked load loses its new reservation if a higher-indexed lane commits a write to the same word in the same cycle. It keeps the reservation if only lower-indexed lanes write that word.
- R9: Word matching ignores the low `OFS_W` address bits, which select a byte within the word.
- R10: Reset (`rst_n` low) clears every reservation, so each conditional store issued after reset fails until a new linked load.
- R11: A plain store always gets `commit` high and `sc_ok` low. Idle lanes (code 2'b00) commit nothing and leave reservations untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_kind | input | 2*NUM_REQ | Per-lane operation code: 00 idle, 01 linked load, 10 conditional store, 11 plain store |
| req_addr | input | NUM_REQ*ADDR_W | Per-lane byte address |
| sc_ok | output | NUM_REQ | Conditional store on that lane succeeded (value to write back) |
| commit | output | NUM_REQ | That lane's store may be written to memory this cycle |

## Verification
The bench builds the monitor with three requesters, an 8-bit address and 2-bit byte offsets. With three lanes, a single cycle can hold a lower-indexed writer, a linked load and a higher-indexed writer at once, which is what the ordering rules of R7 and R8 need. The random phase draws from only four word addresses with random byte offsets. This makes collisions between lanes, and the byte-offset aliasing of R9, frequent rather than rare.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_LINK  = 2'b01,
    OP_COND  = 2'b10,
    OP_STORE = 2'b11
  } llsc_op_e;

  // Two byte addresses name the same aligned word when they agree above the offset bits.
  function automatic logic word_eq(input logic [63:0] a, input logic [63:0] b,
                                   input int unsigned ofs);
    return (a >> ofs) == (b >> ofs);
  endfunction

endpackage

// File: rtl/llsc_order.sv
module llsc_order
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 2
) (
  input  logic [2*NUM_REQ-1:0]      kind,
  input  logic [NUM_REQ*ADDR_W-1:0] addr,
  input  logic [NUM_REQ-1:0]        rsv_valid,
  input  logic [NUM_REQ*ADDR_W-1:0] rsv_addr,
  output logic [NUM_REQ-1:0]        ok,
  output logic [NUM_REQ-1:0]        commit,
  output logic [NUM_REQ-1:0]        lost,
  output logic [NUM_REQ-1:0]        kill
);

  function automatic llsc_op_e op_at(input logic [2*NUM_REQ-1:0] v, input int i);
    return llsc_op_e'(v[2*i +: 2]);
  endfunction

  function automatic logic [63:0] addr_at(input logic [NUM_REQ*ADDR_W-1:0] v, input int i);
    return 64'(v[i*ADDR_W +: ADDR_W]);
  endfunction

  // Lanes resolve in index order: a lane sees the committed writes of all lower lanes.
  always_comb begin
    logic blocked;
    ok     = '0;
    commit = '0;
    lost   = '0;
    kill   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < i; j++)
        if (commit[j] && word_eq(addr_at(addr, j), addr_at(addr, i), OFS_W)) blocked = 1'b1;
      case (op_at(kind, i))
        OP_STORE: commit[i] = 1'b1;
        OP_COND: begin
          if (rsv_valid[i] && !blocked &&
              word_eq(addr_at(rsv_addr, i), addr_at(addr, i), OFS_W)) begin
            ok[i]     = 1'b1;
            commit[i] = 1'b1;
          end
        end
        default: ;
      endcase
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int j = 0; j < NUM_REQ; j++) begin
        if (commit[j] && rsv_valid[i] &&
            word_eq(addr_at(addr, j), addr_at(rsv_addr, i), OFS_W)) kill[i] = 1'b1;
        if (j > i && commit[j] && op_at(kind, i) == OP_LINK &&
            word_eq(addr_at(addr, j), addr_at(addr, i), OFS_W)) lost[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_i,
  input  logic              cond_i,
  input  logic              lost_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (cond_i) begin
      valid_o <= 1'b0;
    end else if (link_i) begin
      valid_o <= !lost_i;
      addr_o  <= addr_i;
    end else if (kill_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_cond_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i |=> !valid_o);

  assert_kill_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && !link_i) |=> !valid_o);

  assert_lost_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && lost_i && !cond_i) |=> !valid_o);

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> !valid_o);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*NUM_REQ-1:0]      req_kind,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  output logic [NUM_REQ-1:0]        sc_ok,
  output logic [NUM_REQ-1:0]        commit
);

  logic [NUM_REQ-1:0]        rsv_valid;
  logic [NUM_REQ*ADDR_W-1:0] rsv_addr;
  logic [NUM_REQ-1:0]        link_lost;
  logic [NUM_REQ-1:0]        rsv_kill;

  llsc_order #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_order (
    .kind      (req_kind),
    .addr      (req_addr),
    .rsv_valid (rsv_valid),
    .rsv_addr  (rsv_addr),
    .ok        (sc_ok),
    .commit    (commit),
    .lost      (link_lost),
    .kill      (rsv_kill)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    logic is_link, is_cond, is_store;
    assign is_link  = llsc_op_e'(req_kind[2*g +: 2]) == OP_LINK;
    assign is_cond  = llsc_op_e'(req_kind[2*g +: 2]) == OP_COND;
    assign is_store = llsc_op_e'(req_kind[2*g +: 2]) == OP_STORE;

    llsc_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_i  (is_link),
      .cond_i  (is_cond),
      .lost_i  (link_lost[g]),
      .kill_i  (rsv_kill[g]),
      .addr_i  (req_addr[g*ADDR_W +: ADDR_W]),
      .valid_o (rsv_valid[g]),
      .addr_o  (rsv_addr[g*ADDR_W +: ADDR_W])
    );

    assert_ok_needs_resv_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok[g] |-> (rsv_valid[g] && is_cond && commit[g] &&
        word_eq(64'(rsv_addr[g*ADDR_W +: ADDR_W]), 64'(req_addr[g*ADDR_W +: ADDR_W]), OFS_W)));

    assert_store_commits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |-> (commit[g] && !sc_ok[g]));

    for (genvar h = g + 1; h < NUM_REQ; h++) begin : g_pair
      assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_ok[g] && word_eq(64'(req_addr[g*ADDR_W +: ADDR_W]),
                             64'(req_addr[h*ADDR_W +: ADDR_W]), OFS_W)) |-> !sc_ok[h]);
    end
  end

endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int P  = 10;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int OW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*N-1:0]  req_kind = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    sc_ok, commit;

  int checks = 0, errors = 0;
  bit done = 0;

  logic          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [1:0]    k [N];
  logic [AW-1:0] a [N];

  always #(P/2) clk = ~clk;

  llsc_monitor #(.NUM_REQ(N), .ADDR_W(AW), .OFS_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .sc_ok(sc_ok), .commit(commit));

  function automatic bit same(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return x[AW-1:OW] == y[AW-1:OW];
  endfunction

  // Expected outputs for the current lane operations and model state.
  function automatic void expect_out(output logic [N-1:0] eok, output logic [N-1:0] ecm);
    eok = '0; ecm = '0;
    for (int i = 0; i < N; i++) begin
      bit taken = 0;
      for (int j = 0; j < i; j++) if (ecm[j] && same(a[j], a[i])) taken = 1;
      if (k[i] == 2'b11) ecm[i] = 1;
      if (k[i] == 2'b10 && m_v[i] && same(m_a[i], a[i]) && !taken) begin
        eok[i] = 1; ecm[i] = 1;
      end
    end
  endfunction

  function automatic void advance(input logic [N-1:0] ecm);
    for (int i = 0; i < N; i++) begin
      bit hit = 0, later = 0;
      for (int j = 0; j < N; j++) begin
        if (ecm[j] && same(a[j], m_a[i])) hit = 1;
        if (j > i && ecm[j] && same(a[j], a[i])) later = 1;
      end
      if (k[i] == 2'b10) m_v[i] = 0;
      else if (k[i] == 2'b01) begin m_v[i] = !later; m_a[i] = a[i]; end
      else if (hit) m_v[i] = 0;
    end
  endfunction

  task automatic put(input int i, input logic [1:0] kk, input logic [AW-1:0] aa);
    k[i] = kk; a[i] = aa;
  endtask

  task automatic idle_all();
    for (int i = 0; i < N; i++) begin k[i] = 2'b00; a[i] = '0; end
  endtask

  // Apply lanes after a rising edge, compare before the next one, then update the model.
  task automatic step(input string req);
    logic [N-1:0] eok, ecm;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin req_kind[2*i +: 2] = k[i]; req_addr[i*AW +: AW] = a[i]; end
    @(negedge clk);
    expect_out(eok, ecm);
    if (!rst_n) begin eok = '0; ecm = commit; end
    checks++;
    if (sc_ok !== eok || commit !== ecm) begin
      errors++;
      $display("FAIL %s: sc_ok=%b commit=%b expected sc_ok=%b commit=%b", req, sc_ok, commit, eok, ecm);
    end
    if (rst_n) advance(ecm);
    else for (int i = 0; i < N; i++) m_v[i] = 0;
    idle_all();
  endtask

  initial begin
    #(P*200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; end
    idle_all();
    rst_n = 0;
    step("R10 reset state");
    step("R10 reset state");
    rst_n = 1;
    put(0, 2'b10, 8'h00); put(1, 2'b10, 8'h00); put(2, 2'b10, 8'h00); step("R10 cond after reset");
    put(0, 2'b01, 8'h10); step("R1 link");
    put(0, 2'b10, 8'h10); step("R1 cond success");
    put(0, 2'b10, 8'h10); step("R4 second cond");
    put(1, 2'b10, 8'h20); step("R2 no reservation");
    put(1, 2'b01, 8'h20); step("R3 link");
    put(1, 2'b10, 8'h24); step("R3 other word");
    put(2, 2'b01, 8'h31); step("R9 link");
    put(2, 2'b10, 8'h33); step("R9 byte offset");
    put(0, 2'b01, 8'h40); step("R5 link");
    put(1, 2'b11, 8'h42); step("R5 foreign store");
    put(0, 2'b10, 8'h40); step("R5 cond after store");
    put(0, 2'b01, 8'h40); step("R5 link");
    put(1, 2'b11, 8'h44); step("R5 store elsewhere");
    put(0, 2'b10, 8'h40); step("R5 cond kept");
    put(0, 2'b01, 8'h50); step("R6 link");
    put(0, 2'b11, 8'h50); step("R6 own store");
    put(0, 2'b10, 8'h50); step("R6 cond after own store");
    put(0, 2'b01, 8'h60); put(1, 2'b01, 8'h60); put(2, 2'b01, 8'h60); step("R7 links");
    put(0, 2'b10, 8'h60); put(1, 2'b10, 8'h61); put(2, 2'b10, 8'h62); step("R7 racing conds");
    put(0, 2'b01, 8'h70); put(2, 2'b11, 8'h70); step("R8 link vs higher store");
    put(0, 2'b10, 8'h70); step("R8 cond lost");
    put(2, 2'b01, 8'h74); put(0, 2'b11, 8'h74); step("R8 link vs lower store");
    put(2, 2'b10, 8'h74); step("R8 cond kept");
    put(1, 2'b01, 8'h80); step("R11 link");
    put(0, 2'b00, 8'h80); put(2, 2'b01, 8'h80); step("R11 idle and link");
    put(1, 2'b10, 8'h80); put(2, 2'b11, 8'h84); step("R11 cond and store");
    put(0, 2'b01, 8'h90); step("R10 link");
    rst_n = 0; step("R10 mid reset");
    rst_n = 1;
    put(0, 2'b10, 8'h90); step("R10 cond after reset");
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++)
        put(i, 2'($urandom_range(0, 3)),
            {6'($urandom_range(0, 3)), 2'($urandom_range(0, 3))});
      step("R1 R4 R5 R7 R8 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule